// File: doc/BRIEF.md
# SMBus Bus-Free Timeout Detector

This block watches the clock and data lines of a two-wire SMBus/I2C port and decides when the bus has been idle long enough to be treated as free. Both lines first pass through a two-flop synchronizer. Idle time is then measured in ticks from the port's bit-rate generator, not in absolute time. The tick is needed for detection even when the port acts only as a target. When both lines have stayed high for more than `TICK_LIMIT` ticks (default 10), the detector declares the bus free and treats the event as an implicit STOP.

The implicit STOP drives a STOP status flag and a sticky interrupt flag. Their response depends on history. A timeout on an addressed transfer raises both flags. A timeout that arrives while a real STOP is still pending clears the STOP flag and leaves the interrupt alone. A timeout after a real STOP that has already been serviced changes nothing. Software clears both flags with a one-cycle strobe.

The detector is a three-state machine:
- `ST_BUSY`: a line is low, or detection is disabled.
- `ST_COUNT`: both lines are high and ticks are being counted.
- `ST_FREE`: the timeout has fired and the bus is free.

The transitions are:
- `ST_BUSY`→`ST_COUNT` when the synchronized lines are both high and the enable is set.
- `ST_COUNT`→`ST_FREE` on the tick that exceeds the limit.
- `ST_COUNT`→`ST_BUSY` and `ST_FREE`→`ST_BUSY` when either line is low or the enable drops.

The count restarts at zero on every entry to `ST_COUNT`. Only ticks that arrive while in `ST_COUNT` are counted.

Top module: `smb_idle_watch`

## Requirements
- R1: After reset, `bus_free`, `stop_flag` and `irq_flag` are 0.
- R2: With `free_en` high and both synchronized lines high, `bus_free` rises at the clock edge of the 11th counted tick; after 10 counted ticks it is still 0.
- R3: A low level on either synchronized line returns the detector to `ST_BUSY`, drops `bus_free` and restarts the count from zero.
- R4: With `free_en` low, no ticks are counted and `bus_free` stays 0; dropping `free_en` while free clears `bus_free` at the next edge.
- R5: The timeout fires at most once per idle period; it re-arms only after a line has gone low.
- R6: A timeout with `addr_hit` high, no pending STOP flag and no serviced real STOP in the current idle period sets `stop_flag` and `irq_flag`; `irq_flag` then stays 1 until `flag_clr`.
- R7: A timeout while `stop_flag` is 1 clears `stop_flag` and leaves `irq_flag` unchanged.
- R8: A timeout after a real STOP that software has already serviced (and with no line low since that STOP) leaves both flags at 0.
- R9: A timeout with `addr_hit` low leaves both flags unchanged, while `bus_free` still rises.
- R10: A `stop_seen` strobe sets `stop_flag` and `irq_flag` at the next edge; `flag_clr` clears both; if both strobes arrive in the same cycle, the set wins.
- R11: Without `src_tick` pulses, the bus is never declared free, however long the lines stay high.
- R12: Line inputs pass through two synchronizer flops: after a line input goes low, `bus_free` is still 1 after one and two edges and falls at the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw serial clock line level |
| sda_in | input | 1 | Raw serial data line level |
| src_tick | input | 1 | One-cycle pulse from the bit-rate clock source |
| free_en | input | 1 | Enables bus-free timeout detection |
| addr_hit | input | 1 | High while this target's address has matched |
| stop_seen | input | 1 | One-cycle strobe for a real STOP condition |
| flag_clr | input | 1 | Software strobe that clears the STOP and interrupt flags |
| bus_free | output | 1 | Bus declared free by timeout |
| stop_flag | output | 1 | STOP status flag |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The bench drives the tick count to exactly 10 and then 11. A detector that is off by one in either direction would flag the bus free one tick early or late. It holds the lines high after a timeout and clears the flags. A detector that does not wait for a line to go low would raise a second interrupt within the same idle period. It also covers the pending-STOP and serviced-STOP cases. A design that treated every timeout as a fresh STOP would set `stop_flag` again in the serviced case, or leave it set in the pending case. Finally, the bench counts edges after a line drops. This exposes a synchronizer with one stage too few or too many as a `bus_free` edge in the wrong cycle.

// File: rtl/smb_idle_pkg.sv
package smb_idle_pkg;
    typedef enum logic [1:0] {
        ST_BUSY  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FREE  = 2'd2
    } idle_state_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2   // must be 2 or more
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/smb_idle_fsm.sv
module smb_idle_fsm
    import smb_idle_pkg::*;
#(
    parameter int TICK_LIMIT = 10,
    localparam int CW = $clog2(TICK_LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_idle,
    input  logic free_en,
    input  logic src_tick,
    output logic timeout_fire,
    output logic bus_free
);
    idle_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          stay_idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BUSY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        stay_idle    = line_idle && free_en;
        state_d      = state_q;
        cnt_d        = cnt_q;
        timeout_fire = 1'b0;
        unique case (state_q)
            ST_BUSY: begin
                cnt_d = '0;
                if (stay_idle) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!stay_idle) begin
                    state_d = ST_BUSY;
                    cnt_d   = '0;
                end else if (src_tick) begin
                    if (cnt_q == CW'(TICK_LIMIT)) begin
                        timeout_fire = 1'b1;
                        state_d      = ST_FREE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FREE: begin
                if (!stay_idle) begin
                    state_d = ST_BUSY;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = ST_BUSY;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        bus_free = (state_q == ST_FREE);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TICK_LIMIT)); // R2
    AST_FREE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_free) |-> $past(src_tick && line_idle)); // R2
    AST_LOW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_idle |=> (state_q == ST_BUSY)); // R3
    AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !free_en |=> !bus_free); // R4
    AST_FIRE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_fire |=> bus_free); // R5
    AST_FREE_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free |-> !timeout_fire); // R5
endmodule

// File: rtl/smb_stop_flags.sv
module smb_stop_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic timeout_fire,
    input  logic line_idle,
    input  logic addr_hit,
    input  logic stop_seen,
    input  logic flag_clr,
    output logic stop_flag,
    output logic irq_flag
);
    logic stop_q, irq_q, done_q;
    logic stop_d, irq_d, done_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            irq_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            stop_q <= stop_d;
            irq_q  <= irq_d;
            done_q <= done_d;
        end
    end

    always_comb begin
        stop_d = stop_q;
        irq_d  = irq_q;
        if (stop_seen) begin
            stop_d = 1'b1;
            irq_d  = 1'b1;
        end else begin
            if (flag_clr) begin
                stop_d = 1'b0;
                irq_d  = 1'b0;
            end
            if (timeout_fire) begin
                if (stop_q) begin
                    stop_d = 1'b0;
                end else if (!done_q && addr_hit) begin
                    stop_d = 1'b1;
                    irq_d  = 1'b1;
                end
            end
        end
        // remembers a real STOP until the bus sees activity again
        if (stop_seen)      done_d = 1'b1;
        else if (!line_idle) done_d = 1'b0;
        else                done_d = done_q;
    end

    assign stop_flag = stop_q;
    assign irq_flag  = irq_q;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !flag_clr |=> irq_q); // R6
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_fire && stop_q && !stop_seen |=> !stop_q); // R7
    AST_PEND_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_fire && stop_q && !stop_seen && !flag_clr |=> irq_q == $past(irq_q)); // R7
    AST_SERVICED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_fire && !stop_q && done_q && !stop_seen |=> !stop_q); // R8
    AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_seen |=> stop_q && irq_q); // R10
endmodule

// File: rtl/smb_idle_watch.sv
module smb_idle_watch #(
    parameter int TICK_LIMIT  = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic src_tick,
    input  logic free_en,
    input  logic addr_hit,
    input  logic stop_seen,
    input  logic flag_clr,
    output logic bus_free,
    output logic stop_flag,
    output logic irq_flag
);
    logic [1:0] lines_s;
    logic       line_idle;
    logic       timeout_fire;

    smb_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sda_in, scl_in}),
        .q   (lines_s)
    );

    assign line_idle = &lines_s;

    smb_idle_fsm #(.TICK_LIMIT(TICK_LIMIT)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_idle    (line_idle),
        .free_en      (free_en),
        .src_tick     (src_tick),
        .timeout_fire (timeout_fire),
        .bus_free     (bus_free)
    );

    smb_stop_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .timeout_fire (timeout_fire),
        .line_idle    (line_idle),
        .addr_hit     (addr_hit),
        .stop_seen    (stop_seen),
        .flag_clr     (flag_clr),
        .stop_flag    (stop_flag),
        .irq_flag     (irq_flag)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !bus_free && !stop_flag && !irq_flag); // R1
endmodule

// File: tb/smb_idle_watch_test.sv
module smb_idle_watch_test;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b0, sda_in = 1'b0, src_tick = 1'b0, free_en = 1'b0;
    logic addr_hit = 1'b0, stop_seen = 1'b0, flag_clr = 1'b0;
    logic bus_free, stop_flag, irq_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done_run = 1'b0;
    string cur_req = "R1";

    // reference state built from the requirements
    logic [1:0] m_s1 = 2'b00, m_s2 = 2'b00;
    int  m_st = 0, m_cnt = 0;
    logic m_stop = 1'b0, m_irq = 1'b0, m_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smb_idle_watch uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .src_tick(src_tick), .free_en(free_en), .addr_hit(addr_hit),
        .stop_seen(stop_seen), .flag_clr(flag_clr),
        .bus_free(bus_free), .stop_flag(stop_flag), .irq_flag(irq_flag)
    );

    function automatic logic exp_free();
        return (m_st == 2);
    endfunction

    task automatic model_step();
        logic idle, fire, ns, ni, nd;
        idle = m_s2[0] & m_s2[1];
        fire = (m_st == 1) && idle && free_en && src_tick && (m_cnt == LIMIT);
        ns = m_stop; ni = m_irq; nd = m_done;
        if (stop_seen) begin ns = 1; ni = 1; end
        else begin
            if (flag_clr) begin ns = 0; ni = 0; end
            if (fire) begin
                if (m_stop) ns = 0;
                else if (!m_done && addr_hit) begin ns = 1; ni = 1; end
            end
        end
        if (stop_seen) nd = 1; else if (!idle) nd = 0;
        case (m_st)
            0: if (free_en && idle) begin m_st = 1; m_cnt = 0; end
            1: if (!(free_en && idle)) begin m_st = 0; m_cnt = 0; end
               else if (fire) m_st = 2;
               else if (src_tick) m_cnt = m_cnt + 1;
            default: if (!(free_en && idle)) begin m_st = 0; m_cnt = 0; end
        endcase
        m_stop = ns; m_irq = ni; m_done = nd;
        m_s2 = m_s1;
        m_s1 = {sda_in, scl_in};
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_cmp();
        n_checks++;
        if (bus_free !== exp_free() || stop_flag !== m_stop || irq_flag !== m_irq) begin
            n_fail++;
            $display("FAIL %s model compare actual=%b%b%b expected=%b%b%b at %0t", cur_req,
                     bus_free, stop_flag, irq_flag, exp_free(), m_stop, m_irq, $time);
        end
    endtask

    task automatic step(logic scl, logic sda, logic tk, logic en, logic hit,
                        logic stp, logic clr);
        scl_in = scl; sda_in = sda; src_tick = tk; free_en = en;
        addr_hit = hit; stop_seen = stp; flag_clr = clr;
        @(posedge clk);
        model_step();
        #(CLK_PERIOD/4);
        model_cmp();
    endtask

    task automatic quiet(int n, logic tk, logic hit);
        for (int i = 0; i < n; i++) step(1, 1, tk, 1, hit, 0, 0);
    endtask

    task automatic low_pulse();
        step(1, 0, 0, 1, 1, 0, 0);
        quiet(3, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!done_run) $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        #(CLK_PERIOD * 3 + 2);
        cur_req = "R1";
        chk("R1", "bus_free", bus_free, 0);
        chk("R1", "stop_flag", stop_flag, 0);
        chk("R1", "irq_flag", irq_flag, 0);
        rst_n = 1'b1;

        // R2 / R6: exact tick count, addressed timeout
        cur_req = "R2";
        quiet(4, 0, 1);
        quiet(LIMIT, 1, 1);
        chk("R2", "bus_free after 10 ticks", bus_free, 0);
        quiet(1, 1, 1);
        chk("R2", "bus_free after 11 ticks", bus_free, 1);
        chk("R6", "stop_flag on timeout", stop_flag, 1);
        chk("R6", "irq_flag on timeout", irq_flag, 1);
        cur_req = "R6";
        quiet(6, 1, 1);
        chk("R6", "irq_flag sticky", irq_flag, 1);
        step(1, 1, 1, 1, 1, 0, 1);
        chk("R6", "irq after clear", irq_flag, 0);

        // R5: no second timeout in the same idle period
        cur_req = "R5";
        quiet(30, 1, 1);
        chk("R5", "no re-fire stop", stop_flag, 0);
        chk("R5", "no re-fire irq", irq_flag, 0);
        chk("R5", "still free", bus_free, 1);

        // R12: synchronizer latency
        cur_req = "R12";
        step(1, 0, 0, 1, 1, 0, 0);
        chk("R12", "free after 1 edge", bus_free, 1);
        step(1, 1, 0, 1, 1, 0, 0);
        chk("R12", "free after 2 edges", bus_free, 1);
        step(1, 1, 0, 1, 1, 0, 0);
        chk("R12", "free drops at 3rd edge", bus_free, 0);

        // R11: no ticks, no timeout
        cur_req = "R11";
        quiet(60, 0, 1);
        chk("R11", "no free without ticks", bus_free, 0);

        // R5: re-armed after a low
        cur_req = "R5";
        quiet(LIMIT + 1, 1, 1);
        chk("R5", "re-armed fire", bus_free, 1);
        chk("R5", "re-armed stop", stop_flag, 1);
        step(1, 1, 0, 1, 1, 0, 1);

        // R3: low mid-count restarts
        cur_req = "R3";
        low_pulse();
        quiet(8, 1, 1);
        step(0, 1, 0, 1, 1, 0, 0);
        quiet(3, 0, 1);
        quiet(LIMIT, 1, 1);
        chk("R3", "count restarted", bus_free, 0);
        quiet(1, 1, 1);
        chk("R3", "free after full count", bus_free, 1);
        step(1, 1, 0, 1, 1, 0, 1);

        // R7: pending real STOP cleared by timeout
        cur_req = "R7";
        low_pulse();
        step(1, 1, 0, 1, 1, 1, 0);
        chk("R10", "stop_seen sets stop", stop_flag, 1);
        chk("R10", "stop_seen sets irq", irq_flag, 1);
        quiet(LIMIT + 1, 1, 1);
        chk("R7", "pending stop cleared", stop_flag, 0);
        chk("R7", "irq unchanged", irq_flag, 1);
        step(1, 1, 0, 1, 1, 0, 1);
        chk("R10", "flag_clr clears irq", irq_flag, 0);

        // R8: serviced STOP, then timeout
        cur_req = "R8";
        low_pulse();
        step(1, 1, 0, 1, 1, 1, 0);
        step(1, 1, 0, 1, 1, 0, 1);
        quiet(LIMIT + 1, 1, 1);
        chk("R8", "free", bus_free, 1);
        chk("R8", "stop not set", stop_flag, 0);
        chk("R8", "irq not set", irq_flag, 0);

        // R9: not addressed
        cur_req = "R9";
        low_pulse();
        quiet(LIMIT + 1, 1, 0);
        chk("R9", "free", bus_free, 1);
        chk("R9", "stop unchanged", stop_flag, 0);
        chk("R9", "irq unchanged", irq_flag, 0);

        // R4: enable low
        cur_req = "R4";
        step(1, 1, 1, 0, 1, 0, 0);
        chk("R4", "free drops with enable", bus_free, 0);
        for (int i = 0; i < 30; i++) step(1, 1, 1, 0, 1, 0, 0);
        chk("R4", "no count while disabled", bus_free, 0);

        // R10: set wins over clear
        cur_req = "R10";
        step(1, 1, 0, 1, 1, 1, 1);
        chk("R10", "set wins stop", stop_flag, 1);
        chk("R10", "set wins irq", irq_flag, 1);
        step(1, 1, 0, 1, 1, 0, 1);

        // random phase against the reference
        cur_req = "R2";
        for (int b = 0; b < 120; b++) begin
            bit calm;
            calm = ($urandom % 2) == 0;
            for (int i = 0; i < 40; i++) begin
                step(calm ? 1'b1 : 1'(($urandom % 4) != 0),
                     calm ? 1'b1 : 1'(($urandom % 4) != 0),
                     1'(($urandom % 2) == 0), 1'(($urandom % 32) != 0),
                     1'(($urandom % 4) != 0), 1'(($urandom % 40) == 0),
                     1'(($urandom % 25) == 0));
            end
        end

        done_run = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule